// File: doc/BRIEF.md
# UART Receive Status Flags

This block keeps the sticky condition flags of a UART receiver. Each time the receive shifter hands a finished character to the receive buffer, it pulses a load strobe. With that strobe it presents what it observed about the character: the level of the first stop bit, whether parity matched, whether a break was seen, and whether the wake condition holds. The block turns these into five flags: framing, parity, overrun, break and wake. It also tracks whether the buffer holds an unread character, so that it can raise overrun without help.

Once raised, a flag stays up until software removes it. Software can read the receive buffer, which clears every flag. It can pulse a per-flag clear bit. It can assert a software reset. A synchronous system reset also clears the flags. When parity is switched off, the parity flag is held at zero. Every flag comes from a register and changes on the clock edge that follows the strobe causing the change.

Top module: `rx_status_flags`

## Requirements
- R1: A system reset (`rst`) or software reset (`soft_rst`) high at a clock edge leaves all five flags at 0 after that edge. It also marks the buffer empty, so the next load does not raise overrun.
- R2: A load with `stop_first` = 0 sets the framing flag, `flags[0]`. A load with `stop_first` = 1 does not set it.
- R3: A load with `par_bad` = 1 while `par_en` = 1 sets the parity flag, `flags[1]`. While `par_en` = 0, `flags[1]` reads 0 from the edge after `par_en` fell, and loads do not set it.
- R4: The overrun flag, `flags[2]`, is set when a load arrives while the buffer holds a character. A character counts as held if it was loaded with no buffer read or reset since, and there is no buffer read in the same cycle as the new load.
- R5: A load with `brk_det` = 1 sets the break flag, `flags[3]`. A load with `wake_det` = 1 sets the wake flag, `flags[4]`.
- R6: A set flag stays set across later loads that do not raise it. It also stays set across idle cycles. Only a buffer read, its software clear bit, a reset, or (for parity) `par_en` = 0 removes it.
- R7: A buffer read (`buf_rd`) without a load clears all five flags at the next edge.
- R8: When a load and a buffer read occur in the same cycle, the new character sets its flags and every older flag is dropped. The flags then equal the new character's conditions, with overrun 0.
- R9: `sw_clr[i]` = 1 clears only `flags[i]`. If a load sets that same flag in the same cycle, the flag ends up set.
- R10: The character indication inputs have no effect while `load_stb` = 0. Flags change only on the clock edge after a strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| soft_rst | input | 1 | Synchronous software reset of all flags and buffer occupancy |
| par_en | input | 1 | Parity checking enabled |
| load_stb | input | 1 | One-cycle pulse: a character enters the receive buffer |
| stop_first | input | 1 | Level of the first stop bit of that character |
| par_bad | input | 1 | Parity mismatch on that character |
| brk_det | input | 1 | Break detected on that character |
| wake_det | input | 1 | Wake condition present for that character |
| buf_rd | input | 1 | One-cycle pulse: software reads the receive buffer |
| sw_clr | input | 5 | Per-flag software clear, bit i clears flags[i] |
| flags | output | 5 | {wake, break, overrun, parity, framing}, bit 0 = framing |

## Verification
Every flag, and the hidden buffer-occupancy bit, changes exactly one edge after the strobe that causes the change. No output is combinational. The bench applies each stimulus at a falling edge and lets one rising edge pass. It then compares the flags at the next falling edge against the expected value that its own model computed for that edge. This keeps every comparison one cycle after its cause, including the same-cycle collisions of load with read and of load with a per-flag clear. It also applies when `par_en` falls and the parity flag drops one edge later.

// File: rtl/rxflag_pkg.sv
package rxflag_pkg;

  localparam int NFLAG = 5;

  localparam int FE_I = 0;
  localparam int PE_I = 1;
  localparam int OE_I = 2;
  localparam int BK_I = 3;
  localparam int WK_I = 4;

  typedef logic [NFLAG-1:0] flagv_t;

endpackage

// File: rtl/rxflag_setgen.sv
module rxflag_setgen
  import rxflag_pkg::*;
(
  input  logic   load_stb,
  input  logic   stop_first,
  input  logic   par_bad,
  input  logic   par_en,
  input  logic   brk_det,
  input  logic   wake_det,
  input  logic   buf_full,
  input  logic   buf_rd,
  output flagv_t set_vec
);

  always_comb begin
    set_vec = '0;
    if (load_stb) begin
      set_vec[FE_I] = ~stop_first;
      set_vec[PE_I] = par_bad & par_en;
      set_vec[OE_I] = buf_full & ~buf_rd;
      set_vec[BK_I] = brk_det;
      set_vec[WK_I] = wake_det;
    end
  end

endmodule

// File: rtl/rxflag_occupancy.sv
module rxflag_occupancy (
  input  logic clk,
  input  logic rst,
  input  logic soft_rst,
  input  logic load_stb,
  input  logic buf_rd,
  output logic buf_full
);

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      buf_full <= 1'b0;
    end else if (load_stb) begin
      buf_full <= 1'b1;
    end else if (buf_rd) begin
      buf_full <= 1'b0;
    end
  end

  AST_LOAD_MARKS_FULL: assert property (@(posedge clk) disable iff (rst)
    (load_stb && !soft_rst) |=> buf_full); // R4

  AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    (buf_rd && !load_stb) |=> !buf_full); // R7

endmodule

// File: rtl/rxflag_cell.sv
module rxflag_cell (
  input  logic clk,
  input  logic rst,
  input  logic soft_rst,
  input  logic rd_clr,
  input  logic sw_clr,
  input  logic set,
  input  logic force_zero,
  output logic q
);

  logic d;

  always_comb begin
    d = set | (q & ~rd_clr & ~sw_clr);
    if (force_zero) d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst) q <= 1'b0;
    else                 q <= d;
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (q && !rd_clr && !sw_clr && !force_zero && !soft_rst) |=> q); // R6

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (set && !force_zero && !soft_rst) |=> q); // R9

endmodule

// File: rtl/rx_status_flags.sv
module rx_status_flags
  import rxflag_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             soft_rst,
  input  logic             par_en,
  input  logic             load_stb,
  input  logic             stop_first,
  input  logic             par_bad,
  input  logic             brk_det,
  input  logic             wake_det,
  input  logic             buf_rd,
  input  logic [NFLAG-1:0] sw_clr,
  output logic [NFLAG-1:0] flags
);

  logic   buf_full;
  flagv_t set_vec;
  flagv_t q_vec;

  rxflag_occupancy u_occ (
    .clk      (clk),
    .rst      (rst),
    .soft_rst (soft_rst),
    .load_stb (load_stb),
    .buf_rd   (buf_rd),
    .buf_full (buf_full)
  );

  rxflag_setgen u_set (
    .load_stb   (load_stb),
    .stop_first (stop_first),
    .par_bad    (par_bad),
    .par_en     (par_en),
    .brk_det    (brk_det),
    .wake_det   (wake_det),
    .buf_full   (buf_full),
    .buf_rd     (buf_rd),
    .set_vec    (set_vec)
  );

  for (genvar i = 0; i < NFLAG; i++) begin : g_cell
    localparam bit IS_PE = (i == PE_I);
    logic fz;
    if (IS_PE) begin : g_mask
      assign fz = ~par_en;
    end else begin : g_nomask
      assign fz = 1'b0;
    end
    rxflag_cell u_cell (
      .clk        (clk),
      .rst        (rst),
      .soft_rst   (soft_rst),
      .rd_clr     (buf_rd),
      .sw_clr     (sw_clr[i]),
      .set        (set_vec[i]),
      .force_zero (fz),
      .q          (q_vec[i])
    );
  end

  assign flags = q_vec;

  AST_SOFT_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (flags == '0)); // R1

  AST_FE_ON_LOW_STOP: assert property (@(posedge clk) disable iff (rst)
    (load_stb && !stop_first && !soft_rst) |=> flags[FE_I]); // R2

  AST_PE_MASKED: assert property (@(posedge clk) disable iff (rst)
    !par_en |=> !flags[PE_I]); // R3

  AST_OVERRUN_ON_FULL: assert property (@(posedge clk) disable iff (rst)
    (buf_full && load_stb && !buf_rd && !soft_rst) |=> flags[OE_I]); // R4

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (buf_rd && !load_stb && !soft_rst) |=> (flags == '0)); // R7

  AST_NO_OVERRUN_ON_READ: assert property (@(posedge clk) disable iff (rst)
    (buf_rd && load_stb) |=> !flags[OE_I]); // R8

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!load_stb && !buf_rd && !soft_rst && (sw_clr == '0) && par_en) |=> $stable(flags)); // R10

endmodule

// File: tb/rx_status_flags_test.sv
`timescale 1ns/1ps
module rx_status_flags_test;

  logic       clk = 1'b0;
  logic       rst, soft_rst, par_en, load_stb, stop_first;
  logic       par_bad, brk_det, wake_det, buf_rd;
  logic [4:0] sw_clr;
  logic [4:0] flags;

  logic [4:0] exp_flags;
  logic       exp_full;
  int         n_run = 0;
  int         n_fail = 0;

  always #4 clk = ~clk;

  rx_status_flags uut (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .par_en(par_en),
    .load_stb(load_stb), .stop_first(stop_first), .par_bad(par_bad),
    .brk_det(brk_det), .wake_det(wake_det), .buf_rd(buf_rd),
    .sw_clr(sw_clr), .flags(flags)
  );

  function automatic logic [5:0] model_next(logic [4:0] f, logic full);
    logic [4:0] setv, keep, nf;
    logic nfull;
    if (rst || soft_rst) begin
      nf = '0; nfull = 1'b0;
    end else begin
      setv = '0;
      if (load_stb) begin
        setv[0] = ~stop_first;
        setv[1] = par_bad & par_en;
        setv[2] = full & ~buf_rd;
        setv[3] = brk_det;
        setv[4] = wake_det;
      end
      keep = buf_rd ? 5'b0 : (f & ~sw_clr);
      nf = setv | keep;
      if (!par_en) nf[1] = 1'b0;
      nfull = load_stb ? 1'b1 : (buf_rd ? 1'b0 : full);
    end
    return {nfull, nf};
  endfunction

  task automatic idle_inputs();
    rst = 0; soft_rst = 0; load_stb = 0; stop_first = 1;
    par_bad = 0; brk_det = 0; wake_det = 0; buf_rd = 0; sw_clr = '0;
  endtask

  task automatic tick(string tag);
    logic [5:0] nx;
    nx = model_next(exp_flags, exp_full);
    @(negedge clk);
    exp_flags = nx[4:0];
    exp_full  = nx[5];
    n_run++;
    if (flags !== exp_flags) begin
      n_fail++;
      $display("FAIL %s: flags actual=%b expected=%b", tag, flags, exp_flags);
    end
    idle_inputs();
  endtask

  task automatic load(logic sb, logic pb, logic bk, logic wk, string tag);
    load_stb = 1; stop_first = sb; par_bad = pb; brk_det = bk; wake_det = wk;
    tick(tag);
  endtask

  initial begin
    #(8 * 20000);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    exp_flags = '0; exp_full = 0;
    par_en = 1;
    idle_inputs();
    @(negedge clk);
    rst = 1; tick("R1 system reset");
    rst = 1; tick("R1 system reset hold");

    // framing on low first stop bit, then read clears
    load(0, 0, 0, 0, "R2 framing set");
    buf_rd = 1; tick("R7 read clears");
    load(1, 0, 0, 0, "R2 good stop no framing");
    buf_rd = 1; tick("R7 read clears again");

    // parity
    load(1, 1, 0, 0, "R3 parity set");
    par_en = 0; tick("R3 parity masked when disabled");
    buf_rd = 1; tick("R7 read");
    load(1, 1, 0, 0, "R3 parity not set while disabled");
    par_en = 1; buf_rd = 1; tick("R7 read");

    // overrun, break, wake, sticky
    load(1, 0, 1, 0, "R5 break set");
    load(1, 0, 0, 1, "R4 overrun and R5 wake");
    load(1, 0, 0, 0, "R6 sticky over clean load");
    tick("R6 sticky idle");
    stop_first = 0; par_bad = 1; brk_det = 1; wake_det = 1;
    tick("R10 indications ignored without load");

    // per-flag clear
    sw_clr = 5'b01000; tick("R9 single flag clear");
    sw_clr = 5'b10000; load_stb = 1; wake_det = 1; tick("R9 set wins over clear");

    // load with read in same cycle
    buf_rd = 1; load_stb = 1; stop_first = 0; tick("R8 load with read");

    // soft reset then load: no overrun
    soft_rst = 1; tick("R1 software reset");
    load(1, 0, 0, 0, "R1 no overrun after reset");
    buf_rd = 1; tick("R7 read");

    // random mix
    for (int k = 0; k < 3000; k++) begin
      load_stb   = ($urandom % 3) == 0;
      stop_first = ($urandom % 4) != 0;
      par_bad    = ($urandom % 4) == 0;
      brk_det    = ($urandom % 5) == 0;
      wake_det   = ($urandom % 5) == 0;
      buf_rd     = ($urandom % 4) == 0;
      sw_clr     = (($urandom % 6) == 0) ? 5'($urandom) : 5'b0;
      soft_rst   = ($urandom % 60) == 0;
      if (($urandom % 40) == 0) par_en = ~par_en;
      tick("R4 R6 R8 R9 random mix");
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule